// File: doc/BRIEF.md
# Capture Timer with Aliased Capture Storage

This block is a timer/counter that works either as an 8-bit or as a 16-bit counter. A time-stamp of the counter is taken when an external event arrives. The event comes from a dedicated capture pin or from an analog comparator result bit, chosen by a control bit. The chosen signal passes through a two-flop synchronizer, then an optional glitch filter, then a rising/falling edge detector. A matching edge copies the counter into the capture storage and raises a capture flag.

There is no separate capture register. The low byte of each time-stamp lands in compare register A. In 16-bit mode the high byte lands in compare register B, and the compare-match output is forced low. In 8-bit mode compare register B keeps its normal compare role. The counter advances on a prescaler tick (`clk_en`) while the clock-select field is nonzero. Software reaches all state through a small byte-wide register port, which uses a staging byte so that 16-bit counter values are read and written as one unit.

The edge detector is a two-state machine. **LVL_LO** goes to **LVL_HI** when the conditioned level rises. This transition fires a capture if rising edges are selected. **LVL_HI** goes to **LVL_LO** when the level falls. This transition fires a capture if falling edges are selected. The machine leaves reset in LVL_LO.

Top module: `capture_timer`

## Requirements
- R1: The counter holds its value while the clock-select field (CTRL bits 2:0, CTRL at address 0) is zero, even with `clk_en` high. Software can still write and read the counter at address 1 (low byte) and address 2 (high byte) while it is stopped. When the field is nonzero, the counter advances by one on each clock with `clk_en` high.
- R2: A software write to the counter low byte in a cycle with a tick stores the written value, and the increment for that cycle is dropped.
- R3: The overflow flag (FLAGS bit 1, FLAGS at address 5, also the `ovf_flag` port) sets on the tick that brings the counter to its top value. The top value is 0x00FF in 8-bit mode and 0xFFFF in 16-bit mode (CTRL bit 3 = 1 selects 16-bit mode). In 16-bit mode, stepping from 0x00FF to 0x0100 does not set the flag.
- R4: CTRL bit 4 selects the capture source: 0 is `cap_pin` and 1 is `cmp_out`. The source that is not selected never triggers a capture.
- R5: CTRL bit 5 selects the capture edge: 1 is rising and 0 is falling. An edge in the other direction triggers no capture.
- R6: With CTRL bit 6 clear, a change on the input sets the capture flag at the third rising clock edge after the change. With the bit set, the level must hold for four samples, which adds four clocks. A pulse of two clocks is then ignored.
- R7: A capture copies the counter low byte into compare register A (address 3) and sets the capture flag (FLAGS bit 0, also the `cap_flag` port).
- R8: In 16-bit mode a capture also copies the counter high byte into compare register B (address 4), and `match_b` stays low. In 8-bit mode a capture leaves register B unchanged, and `match_b` is high when the counter low byte equals register B.
- R9: Reading the counter low byte in 16-bit mode copies the counter high byte into the staging byte. Address 2 reads the staging byte. Writing address 2 changes only the staging byte. The next low-byte write loads both bytes at once.
- R10: Writing 1 to a FLAGS bit clears that flag. Writing 0 leaves it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Prescaler tick; the counter advances on cycles where it is high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; used for the low-byte staging side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cap_pin | input | 1 | External capture input |
| cmp_out | input | 1 | Analog comparator result bit |
| cap_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Overflow flag |
| match_b | output | 1 | Counter low byte equals compare register B (8-bit mode only) |

## Verification
The hardest case to reach from the ports is an exact capture value. When the counter is running, the captured byte depends on synchronizer and filter latency. The bench therefore stops the counter through the clock-select field, loads a known preset, and only then toggles the chosen input, so the expected capture is simply the preset. Latency is measured on its own, edge by edge, with and without the filter. A two-clock glitch is used to show that the filter rejects short pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_CNT_L = 3'd1,
        REG_CNT_H = 3'd2,
        REG_CMP_A = 3'd3,
        REG_CMP_B = 3'd4,
        REG_FLAGS = 3'd5
    } reg_addr_e;

    localparam int CTRL_WIDE = 3;
    localparam int CTRL_SRC  = 4;
    localparam int CTRL_RISE = 5;
    localparam int CTRL_FILT = 6;

    localparam int FLAG_CAP = 0;
    localparam int FLAG_OVF = 1;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/tmr_in_cond.sv
module tmr_in_cond #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic filt_en,
    output logic level
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [STAGES-1:0] sync_q;
    logic              sampled;
    logic              filt_q;
    logic [CW-1:0]     run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], raw_in};
    end

    assign sampled = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
        end else if (sampled != filt_q) begin
            if (run_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sampled;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign level = filt_en ? filt_q : sampled;
endmodule

// File: rtl/tmr_edge_fsm.sv
module tmr_edge_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    output logic trig
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        trig    = 1'b0;
        unique case (state_q)
            LVL_LO: if (level) begin
                state_d = LVL_HI;
                trig    = rise_sel;
            end
            LVL_HI: if (!level) begin
                state_d = LVL_LO;
                trig    = !rise_sel;
            end
        endcase
    end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cap_pin,
    input  logic       cmp_out,
    output logic       cap_flag,
    output logic       ovf_flag,
    output logic       match_b
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] TOP_WIDE   = '1;
    localparam logic [CNT_W-1:0] TOP_NARROW = CNT_W'({BYTE_W{1'b1}});

    logic [BYTE_W-1:0] ctrl_q, cmpa_q, cmpb_q, temp_q;
    logic [CNT_W-1:0]  cnt_q, cnt_inc, cnt_wval, top_val;
    logic              cap_q, ovf_q;
    logic              wide, running, tick, cnt_wr, trig, level, raw_sel;

    assign wide    = ctrl_q[CTRL_WIDE];
    assign running = |ctrl_q[2:0];
    assign tick    = running && clk_en;
    assign cnt_wr  = bus_wr && (bus_addr == REG_CNT_L);
    assign top_val = wide ? TOP_WIDE : TOP_NARROW;
    assign cnt_inc = wide ? cnt_q + 1'b1
                          : {{BYTE_W{1'b0}}, cnt_q[BYTE_W-1:0] + 1'b1};
    assign cnt_wval = wide ? {temp_q, bus_wdata} : {{BYTE_W{1'b0}}, bus_wdata};
    assign raw_sel  = ctrl_q[CTRL_SRC] ? cmp_out : cap_pin;

    tmr_in_cond #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_sel),
        .filt_en(ctrl_q[CTRL_FILT]), .level(level)
    );

    tmr_edge_fsm u_edge (
        .clk(clk), .rst_n(rst_n), .level(level),
        .rise_sel(ctrl_q[CTRL_RISE]), .trig(trig)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            temp_q <= '0;
            cmpa_q <= '0;
            cmpb_q <= '1;
            cap_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == REG_CTRL) ctrl_q <= {1'b0, bus_wdata[6:0]};

            if (cnt_wr)    cnt_q <= cnt_wval;
            else if (tick) cnt_q <= cnt_inc;

            if (bus_wr && bus_addr == REG_CNT_H)                temp_q <= bus_wdata;
            else if (bus_rd && bus_addr == REG_CNT_L && wide)   temp_q <= cnt_q[CNT_W-1:BYTE_W];

            if (bus_wr && bus_addr == REG_CMP_A) cmpa_q <= bus_wdata;
            else if (trig)                       cmpa_q <= cnt_q[BYTE_W-1:0];

            if (bus_wr && bus_addr == REG_CMP_B) cmpb_q <= bus_wdata;
            else if (trig && wide)               cmpb_q <= cnt_q[CNT_W-1:BYTE_W];

            if (trig)                                           cap_q <= 1'b1;
            else if (bus_wr && bus_addr == REG_FLAGS && bus_wdata[FLAG_CAP]) cap_q <= 1'b0;

            if (tick && !cnt_wr && cnt_inc == top_val)          ovf_q <= 1'b1;
            else if (bus_wr && bus_addr == REG_FLAGS && bus_wdata[FLAG_OVF]) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_CNT_L: bus_rdata = cnt_q[BYTE_W-1:0];
            REG_CNT_H: bus_rdata = temp_q;
            REG_CMP_A: bus_rdata = cmpa_q;
            REG_CMP_B: bus_rdata = cmpb_q;
            REG_FLAGS: bus_rdata = {6'b0, ovf_q, cap_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign cap_flag = cap_q;
    assign ovf_flag = ovf_q;
    assign match_b  = !wide && (cnt_q[BYTE_W-1:0] == cmpb_q);
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cs,
    input logic        wide,
    input logic [15:0] cnt,
    input logic [7:0]  cmpa,
    input logic        cap_flag,
    input logic        ovf_flag,
    input logic        match_b,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata
);
    p_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == 3'd0 && !(bus_wr && bus_addr == 3'd1)) |=> $stable(cnt));

    p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (cnt[7:0] == $past(bus_wdata)));

    p_ovf_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt == (wide ? 16'hFFFF : 16'h00FF)));

    p_cap_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cap_flag) && !$past(bus_wr && bus_addr == 3'd3)) |-> (cmpa == $past(cnt[7:0])));

    p_no_match_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> !match_b);
endmodule

bind capture_timer capture_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(ctrl_q[2:0]), .wide(wide), .cnt(cnt_q),
    .cmpa(cmpa_q), .cap_flag(cap_flag), .ovf_flag(ovf_flag), .match_b(match_b),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_capture_timer.sv
module test_capture_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0, cmp_out = 1'b0;
    logic       cap_flag, ovf_flag, match_b;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    capture_timer i_capture_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cmp_out(cmp_out), .cap_flag(cap_flag),
        .ovf_flag(ovf_flag), .match_b(match_b)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] preset;
        logic        tog_cmp;
        logic        lvl0;
        logic        lvl1;
        logic        exp_cap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h20, 16'h0034, 1'b0, 1'b0, 1'b1, 1'b1},
        '{8'h20, 16'h0035, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h00, 16'h0056, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'h28, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1},
        '{8'h30, 16'h0077, 1'b1, 1'b0, 1'b1, 1'b1},
        '{8'h30, 16'h0078, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h60, 16'h0099, 1'b0, 1'b0, 1'b1, 1'b1},
        '{8'h48, 16'hABCD, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd(3'd0, d); check("R1 reset ctrl", 16'(d), 16'h00);
        rd(3'd1, d); check("R1 reset count", 16'(d), 16'h00);
        rd(3'd5, d); check("R10 reset flags", 16'(d), 16'h00);
        check("R8 reset match", 16'(match_b), 16'h0);

        // vector table: captures with stopped counter
        foreach (VECS[i]) begin
            vec_t v;
            logic wide_v;
            v = VECS[i];
            wide_v = v.ctrl[3];
            wr(3'd0, v.ctrl);
            @(negedge clk);
            cap_pin = 1'b0; cmp_out = 1'b0;
            if (v.tog_cmp) cmp_out = v.lvl0; else cap_pin = v.lvl0;
            repeat (12) @(negedge clk);
            wr(3'd3, 8'h00);
            wr(3'd4, 8'hEE);
            wr(3'd5, 8'h03);
            if (wide_v) wr(3'd2, v.preset[15:8]);
            wr(3'd1, v.preset[7:0]);
            if (v.tog_cmp) cmp_out = v.lvl1; else cap_pin = v.lvl1;
            repeat (14) @(negedge clk);
            rd(3'd5, d); check("R4 R5 R7 capture flag", 16'(d[0]), 16'(v.exp_cap));
            rd(3'd3, d); check("R7 compare A value", 16'(d), v.exp_cap ? 16'(v.preset[7:0]) : 16'h00);
            rd(3'd4, d); check("R8 compare B value", 16'(d),
                               (v.exp_cap && wide_v) ? 16'(v.preset[15:8]) : 16'hEE);
        end
        cap_pin = 1'b0; cmp_out = 1'b0;

        // R6 latency without filter (rising, pin source, stopped)
        wr(3'd0, 8'h20);
        repeat (12) @(negedge clk);
        wr(3'd5, 8'h03);
        @(negedge clk); cap_pin = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R6 no capture after 2 edges", 16'(cap_flag), 16'h0);
        @(posedge clk); #1;
        check("R6 capture at 3rd edge", 16'(cap_flag), 16'h1);
        @(negedge clk); cap_pin = 1'b0;

        // R6 latency with filter
        wr(3'd0, 8'h60);
        repeat (14) @(negedge clk);
        wr(3'd5, 8'h03);
        @(negedge clk); cap_pin = 1'b1;
        repeat (6) @(posedge clk); #1;
        check("R6 filtered no capture at 6th edge", 16'(cap_flag), 16'h0);
        @(posedge clk); #1;
        check("R6 filtered capture at 7th edge", 16'(cap_flag), 16'h1);
        @(negedge clk); cap_pin = 1'b0;
        repeat (14) @(negedge clk);

        // R6 glitch rejection with filter, accepted without
        wr(3'd5, 8'h03);
        @(negedge clk); cap_pin = 1'b1;
        repeat (2) @(negedge clk); cap_pin = 1'b0;
        repeat (14) @(negedge clk);
        check("R6 filtered glitch ignored", 16'(cap_flag), 16'h0);
        wr(3'd0, 8'h20);
        repeat (4) @(negedge clk);
        wr(3'd5, 8'h03);
        @(negedge clk); cap_pin = 1'b1;
        repeat (2) @(negedge clk); cap_pin = 1'b0;
        repeat (8) @(negedge clk);
        check("R6 unfiltered glitch captured", 16'(cap_flag), 16'h1);

        // R1 stopped counter holds, running counter moves
        clk_en = 1'b1;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h10);
        repeat (20) @(negedge clk);
        rd(3'd1, d); check("R1 stopped holds", 16'(d), 16'h10);
        wr(3'd0, 8'h01);
        repeat (5) @(negedge clk);
        rd(3'd1, d); nchk++;
        if (d == 8'h10) begin nerr++; $display("FAIL R1 running: actual 0x%0h expected change", d); end

        // R2 write beats increment
        wr(3'd1, 8'h80);
        rd(3'd1, d); check("R2 write priority", 16'(d), 16'h81);

        // R3 overflow in 8-bit mode, R10 clear
        clk_en = 1'b0;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'hFE);
        wr(3'd5, 8'h03);
        wr(3'd0, 8'h01);
        check("R3 ovf before top", 16'(ovf_flag), 16'h0);
        @(negedge clk); clk_en = 1'b1;
        @(negedge clk); clk_en = 1'b0;
        check("R3 ovf at 0xFF", 16'(ovf_flag), 16'h1);
        wr(3'd5, 8'h00);
        check("R10 write zero keeps flag", 16'(ovf_flag), 16'h1);
        wr(3'd5, 8'h02);
        check("R10 write one clears flag", 16'(ovf_flag), 16'h0);

        // R3 16-bit: 0x00FF -> 0x0100 is not the top
        wr(3'd0, 8'h08);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h09);
        @(negedge clk); clk_en = 1'b1;
        @(negedge clk); clk_en = 1'b0;
        check("R3 no ovf at 0x0100 wide", 16'(ovf_flag), 16'h0);
        rd(3'd1, d); check("R3 wide low byte", 16'(d), 16'h00);
        rd(3'd2, d); check("R9 wide high via staging", 16'(d), 16'h01);

        // R9 staged 16-bit access
        wr(3'd0, 8'h08);
        wr(3'd2, 8'h5A);
        wr(3'd1, 8'h3C);
        wr(3'd2, 8'h77);
        rd(3'd1, d); check("R9 low byte", 16'(d), 16'h3C);
        rd(3'd2, d); check("R9 high write alone ignored", 16'(d), 16'h5A);

        // R8 match in 8-bit mode, suppressed in 16-bit mode
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h40);
        wr(3'd1, 8'h40);
        check("R8 match narrow", 16'(match_b), 16'h1);
        wr(3'd0, 8'h08);
        check("R8 match suppressed wide", 16'(match_b), 16'h0);

        finish_run();
    end
endmodule